// File: doc/BRIEF.md
# PMIC Channel Command Engine

This block is a register-mapped command channel for a host that runs read and write transactions toward peripheral registers on a power-management serial bus. The host first loads up to eight outgoing bytes into two 32-bit data words. It then writes a command word, which carries an opcode, a 4-bit slave ID, a 16-bit register address and a length field. The engine decodes the command and moves one byte per clock. When the transfer ends it posts a status word. A completed read returns its bytes in two read-data words.

The far end of the bus is modelled by a small internal array. A parameter mask marks which slave IDs exist, and only those slaves get storage. Each slave holds a window of registers selected by the low address bits, and the address wraps inside that window. Non-data commands (reset, sleep, shutdown, wakeup) change the state of one slave. A host that sees no done bit within about 100 microseconds of polling should declare a timeout.

Top module: `pmic_chan_engine`

## Requirements
- R1: Host register byte offsets: command 0x00 (write-only, reads 0), config 0x04 (bit 0 = enable, reset value 1), status 0x08, write data 0x10 and 0x14, read data 0x18 and 0x1C. The status and read-data words ignore host writes. All registers except config reset to zero.
- R2: The command word holds the opcode in bits 31:27, the slave ID in bits 23:20, the register address in bits 19:4 and the length field in bits 2:0. The slave register used is the address modulo the window size.
- R3: A data command moves (length field + 1) bytes, one byte per clock, at consecutive addresses that wrap within the window. Done is first visible N cycles after the accepting edge, where N is the number of bytes. The bench measures this latency from the accepting edge.
- R4: Byte k of a transfer is bits 8k+7:8k of the combined value {data word 1, data word 0}, least significant byte first. The second word is used only when more than four bytes move. Read-data byte lanes past the transfer length read zero.
- R5: Status bits: bit 0 done, bit 1 failure, bit 2 denied, bit 3 dropped. Failure and denied appear only together with done. The status word clears to zero on the edge that accepts a command.
- R6: Opcodes 0, 2, 14 and 16 write. Opcodes 1, 13 and 15 read. Opcodes 14 and 15 always move exactly one byte, whatever the length field holds.
- R7: Opcode 16 (zero-write) stores bits 6:0 of data byte 0, with bit 7 cleared, into slave register 0. It ignores the address and length fields and completes one cycle after acceptance.
- R8: Opcodes 3 to 6 are non-data commands that complete with done one cycle after acceptance. Opcode 3 clears all registers of that slave and leaves it active. Opcodes 4 and 5 suspend the slave and opcode 6 resumes it. A data access to a suspended slave completes with done and failure.
- R9: Any opcode outside 0-6, 13-16 completes one cycle after acceptance with done and denied, and changes no slave register.
- R10: A command write that arrives while a transfer is in progress sets dropped at once. The new command is discarded, and the running transfer finishes normally with done and dropped set.
- R11: A command to a slave ID that is absent from the presence mask completes one cycle after acceptance with done and failure, and touches no storage.
- R12: The read-data words change only when a read completes successfully. Writes, rejected commands and failed reads leave them unchanged.
- R13: While config bit 0 is clear, every accepted command completes one cycle later with done and denied, and no slave register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe for one cycle |
| bus_addr | input | 5 | Host register byte offset, used for both reads and writes |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Contents of the register at bus_addr, combinational |

## Verification
The bench targets the wrap of an eight-byte transfer across the end of the register window. A design that did not wrap would write past the window or alias to the wrong register. It checks that a five-byte read fills only the first lane of the second word; a design with bad lane steering would leak stale bytes there. It checks that single-byte opcodes ignore a length field of 7, which a careless decoder would turn into an eight-byte transfer that corrupts neighbouring registers. Other targets are a command landing mid-transfer, which must not overwrite the latched command or data, and the read words, which must survive failed and rejected reads. Latency is measured against the byte count to catch an off-by-one in the end-of-transfer test.

// File: rtl/pmic_chan_pkg.sv
package pmic_chan_pkg;

    localparam int SID_W = 4;
    localparam int SID_N = 1 << SID_W;

    // host register byte offsets
    localparam logic [4:0] OFS_CMD = 5'h00;
    localparam logic [4:0] OFS_CFG = 5'h04;
    localparam logic [4:0] OFS_STS = 5'h08;
    localparam logic [4:0] OFS_WD0 = 5'h10;
    localparam logic [4:0] OFS_WD1 = 5'h14;
    localparam logic [4:0] OFS_RD0 = 5'h18;
    localparam logic [4:0] OFS_RD1 = 5'h1C;

    // opcode values
    localparam logic [4:0] OPC_XWRL = 5'd0;
    localparam logic [4:0] OPC_XRDL = 5'd1;
    localparam logic [4:0] OPC_XWR  = 5'd2;
    localparam logic [4:0] OPC_RST  = 5'd3;
    localparam logic [4:0] OPC_SLP  = 5'd4;
    localparam logic [4:0] OPC_SHD  = 5'd5;
    localparam logic [4:0] OPC_WAK  = 5'd6;
    localparam logic [4:0] OPC_XRD  = 5'd13;
    localparam logic [4:0] OPC_WR   = 5'd14;
    localparam logic [4:0] OPC_RD   = 5'd15;
    localparam logic [4:0] OPC_ZWR  = 5'd16;

    typedef enum logic [1:0] {K_WRITE, K_READ, K_CTRL, K_BAD} kind_e;
    typedef enum logic {S_IDLE, S_RUN} seq_state_e;

    typedef struct packed {
        logic [4:0]       op;
        logic [SID_W-1:0] sid;
        logic [15:0]      addr;
        logic [2:0]       cnt;
    } cmd_t;

    typedef struct packed {
        logic dropped;
        logic denied;
        logic failure;
        logic done;
    } sts_t;

    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.op   = w[31:27];
        c.sid  = w[23:20];
        c.addr = w[19:4];
        c.cnt  = w[2:0];
        return c;
    endfunction

    function automatic kind_e op_kind(input logic [4:0] op);
        kind_e k;
        case (op)
            OPC_XWRL, OPC_XWR, OPC_WR, OPC_ZWR:   k = K_WRITE;
            OPC_XRDL, OPC_XRD, OPC_RD:            k = K_READ;
            OPC_RST, OPC_SLP, OPC_SHD, OPC_WAK:   k = K_CTRL;
            default:                              k = K_BAD;
        endcase
        return k;
    endfunction

    function automatic logic [3:0] op_len(input logic [4:0] op, input logic [2:0] cnt);
        if (op == OPC_WR || op == OPC_RD || op == OPC_ZWR)
            return 4'd1;
        return {1'b0, cnt} + 4'd1;
    endfunction

endpackage

// File: rtl/pmic_chan_target.sv
module pmic_chan_target
    import pmic_chan_pkg::*;
#(
    parameter int               WIN     = 32,
    parameter logic [SID_N-1:0] PRESENT = 16'h00FF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SID_W-1:0]       acc_sid,
    input  logic [$clog2(WIN)-1:0] acc_ofs,
    input  logic                   acc_we,
    input  logic [7:0]             acc_wbyte,
    output logic [7:0]             acc_rbyte,
    input  logic                   ctl_en,
    input  logic [4:0]             ctl_op,
    output logic                   q_present,
    output logic                   q_awake
);
    localparam int OFS_W = $clog2(WIN);

    logic [7:0]       rbyte_arr [SID_N];
    logic [SID_N-1:0] awake_arr;

    for (genvar s = 0; s < SID_N; s++) begin : g_slave
        if (PRESENT[s]) begin : g_on
            logic [7:0] regs [WIN];
            logic       awake;
            logic       sel;
            assign sel = (acc_sid == SID_W'(s));

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int w = 0; w < WIN; w++) regs[w] <= '0;
                    awake <= 1'b1;
                end else begin
                    if (acc_we && sel)
                        regs[acc_ofs] <= acc_wbyte;
                    if (ctl_en && sel) begin
                        case (ctl_op)
                            OPC_RST: begin
                                for (int w = 0; w < WIN; w++) regs[w] <= '0;
                                awake <= 1'b1;
                            end
                            OPC_SLP, OPC_SHD: awake <= 1'b0;
                            OPC_WAK:          awake <= 1'b1;
                            default:          awake <= awake;
                        endcase
                    end
                end
            end
            assign rbyte_arr[s] = regs[acc_ofs];
            assign awake_arr[s] = awake;
        end else begin : g_off
            assign rbyte_arr[s] = 8'h00;
            assign awake_arr[s] = 1'b0;
        end
    end

    assign acc_rbyte = rbyte_arr[acc_sid];
    assign q_present = PRESENT[acc_sid];
    assign q_awake   = awake_arr[acc_sid];

    AST_ACC_CTL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(acc_we && ctl_en)); // R8
    AST_NO_ABSENT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_we || ctl_en) |-> PRESENT[acc_sid]); // R11
    AST_NO_SLEEP_WRITE: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> q_awake); // R8

    logic unused_ofs_w;
    assign unused_ofs_w = (OFS_W > 0);
endmodule

// File: rtl/pmic_chan_seq.sv
module pmic_chan_seq
    import pmic_chan_pkg::*;
#(
    parameter int WIN = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [31:0]            cmd_word,
    input  logic [31:0]            wd0,
    input  logic [31:0]            wd1,
    input  logic                   cfg_en,
    input  logic                   q_present,
    input  logic                   q_awake,
    input  logic [7:0]             acc_rbyte,
    output sts_t                   sts,
    output logic [31:0]            rd0,
    output logic [31:0]            rd1,
    output logic [SID_W-1:0]       acc_sid,
    output logic [$clog2(WIN)-1:0] acc_ofs,
    output logic                   acc_we,
    output logic [7:0]             acc_wbyte,
    output logic                   ctl_en,
    output logic [4:0]             ctl_op
);
    localparam int OFS_W = $clog2(WIN);

    seq_state_e  state;
    cmd_t        cur;
    logic [63:0] wbuf;
    logic [63:0] rbuf;
    logic [63:0] rnext;
    logic [3:0]  idx;
    logic [3:0]  len;
    kind_e       kind;
    sts_t        sts_n;
    logic        run, is_zero, rej, fail, ctl, xfer, last;

    assign kind    = op_kind(cur.op);
    assign len     = op_len(cur.op, cur.cnt);
    assign is_zero = (cur.op == OPC_ZWR);
    assign run     = (state == S_RUN);
    assign rej     = run && (!cfg_en || kind == K_BAD);
    assign fail    = run && !rej && (!q_present || (kind != K_CTRL && !q_awake));
    assign ctl     = run && !rej && !fail && (kind == K_CTRL);
    assign xfer    = run && !rej && !fail && (kind == K_WRITE || kind == K_READ);
    assign last    = xfer && (idx == len - 4'd1);

    assign acc_sid   = cur.sid;
    assign acc_ofs   = is_zero ? '0 : cur.addr[OFS_W-1:0] + OFS_W'(idx);
    assign acc_we    = xfer && (kind == K_WRITE);
    assign acc_wbyte = is_zero ? {1'b0, wbuf[6:0]} : wbuf[{idx[2:0], 3'b000} +: 8];
    assign ctl_en    = ctl;
    assign ctl_op    = cur.op;

    always_comb begin
        rnext = rbuf;
        if (kind == K_READ)
            rnext[{idx[2:0], 3'b000} +: 8] = acc_rbyte;
    end

    always_comb begin
        sts_n = sts;
        if (rej) begin
            sts_n.done   = 1'b1;
            sts_n.denied = 1'b1;
        end else if (fail) begin
            sts_n.done    = 1'b1;
            sts_n.failure = 1'b1;
        end else if (ctl || last) begin
            sts_n.done = 1'b1;
        end
        if (go) begin
            if (run) sts_n.dropped = 1'b1;
            else     sts_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
            wbuf  <= '0;
            rbuf  <= '0;
            idx   <= '0;
            sts   <= '0;
            rd0   <= '0;
            rd1   <= '0;
        end else begin
            sts <= sts_n;
            if (xfer) begin
                idx  <= idx + 4'd1;
                rbuf <= rnext;
            end
            if (rej || fail || ctl || last)
                state <= S_IDLE;
            if (last && kind == K_READ) begin
                rd0 <= rnext[31:0];
                rd1 <= rnext[63:32];
            end
            if (go && !run) begin
                state <= S_RUN;
                cur   <= unpack_cmd(cmd_word);
                wbuf  <= {wd1, wd0};
                rbuf  <= '0;
                idx   <= '0;
            end
        end
    end

    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        (sts.failure || sts.denied) |-> sts.done); // R5
    AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (go && state == S_IDLE) |=> (sts == sts_t'(4'b0000) && state == S_RUN)); // R5
    AST_DROP_DISCARDS: assert property (@(posedge clk) disable iff (rst)
        (go && state == S_RUN) |=> (sts.dropped && $stable(cur) && $stable(wbuf))); // R10
    AST_RD_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |=> ($stable(rd0) && $stable(rd1))); // R12
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (idx < len)); // R3
    AST_SHORT_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (xfer && (cur.op == OPC_WR || cur.op == OPC_RD)) |-> (idx == 4'd0)); // R6
endmodule

// File: rtl/pmic_chan_hostif.sv
module pmic_chan_hostif
    import pmic_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  sts_t        sts,
    input  logic [31:0] rd0,
    input  logic [31:0] rd1,
    output logic        go,
    output logic [31:0] cmd_word,
    output logic [31:0] wd0,
    output logic [31:0] wd1,
    output logic        cfg_en
);
    assign go       = bus_we && (bus_addr == OFS_CMD);
    assign cmd_word = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            wd0    <= '0;
            wd1    <= '0;
            cfg_en <= 1'b1;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_WD0: wd0    <= bus_wdata;
                OFS_WD1: wd1    <= bus_wdata;
                OFS_CFG: cfg_en <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CFG: bus_rdata = {31'b0, cfg_en};
            OFS_STS: bus_rdata = {28'b0, sts};
            OFS_WD0: bus_rdata = wd0;
            OFS_WD1: bus_rdata = wd1;
            OFS_RD0: bus_rdata = rd0;
            OFS_RD1: bus_rdata = rd1;
            default: bus_rdata = '0;
        endcase
    end

    AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_CFG) |=> $stable(cfg_en)); // R1
endmodule

// File: rtl/pmic_chan_engine.sv
module pmic_chan_engine
    import pmic_chan_pkg::*;
#(
    parameter int               WIN     = 32,
    parameter logic [SID_N-1:0] PRESENT = 16'h00FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int OFS_W = $clog2(WIN);

    sts_t             sts;
    logic [31:0]      rd0, rd1, wd0, wd1, cmd_word;
    logic             go, cfg_en;
    logic [SID_W-1:0] acc_sid;
    logic [OFS_W-1:0] acc_ofs;
    logic             acc_we, ctl_en, q_present, q_awake;
    logic [7:0]       acc_wbyte, acc_rbyte;
    logic [4:0]       ctl_op;

    pmic_chan_hostif u_host (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts(sts),
        .rd0(rd0), .rd1(rd1), .go(go), .cmd_word(cmd_word),
        .wd0(wd0), .wd1(wd1), .cfg_en(cfg_en)
    );

    pmic_chan_seq #(.WIN(WIN)) u_seq (
        .clk(clk), .rst(rst), .go(go), .cmd_word(cmd_word),
        .wd0(wd0), .wd1(wd1), .cfg_en(cfg_en), .q_present(q_present),
        .q_awake(q_awake), .acc_rbyte(acc_rbyte), .sts(sts),
        .rd0(rd0), .rd1(rd1), .acc_sid(acc_sid), .acc_ofs(acc_ofs),
        .acc_we(acc_we), .acc_wbyte(acc_wbyte), .ctl_en(ctl_en), .ctl_op(ctl_op)
    );

    pmic_chan_target #(.WIN(WIN), .PRESENT(PRESENT)) u_tgt (
        .clk(clk), .rst(rst), .acc_sid(acc_sid), .acc_ofs(acc_ofs),
        .acc_we(acc_we), .acc_wbyte(acc_wbyte), .acc_rbyte(acc_rbyte),
        .ctl_en(ctl_en), .ctl_op(ctl_op), .q_present(q_present), .q_awake(q_awake)
    );
endmodule

// File: tb/sim_pmic_chan_engine.sv
module sim_pmic_chan_engine;
    localparam int          T_CLK = 10;
    localparam int          WINB  = 32;
    localparam logic [15:0] PRES  = 16'h00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #(T_CLK/2) clk = ~clk;

    pmic_chan_engine #(.WIN(WINB), .PRESENT(PRES)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_mem [16][WINB];
    logic [15:0] m_awake;
    logic [3:0]  m_sts;
    logic [31:0] m_rd0, m_rd1, m_wd0, m_wd1, m_cmd;
    logic [63:0] m_wl, m_rt;
    logic        m_cfg, m_busy;
    int          m_idx;

    always @(posedge clk) begin
        logic was_busy, isw, isr, isc;
        int op, sid, lo, cnt, n, k;
        if (rst) begin
            for (int s = 0; s < 16; s++)
                for (int w = 0; w < WINB; w++) m_mem[s][w] = 8'h00;
            m_awake = '1; m_sts = 0; m_rd0 = 0; m_rd1 = 0; m_wd0 = 0; m_wd1 = 0;
            m_cmd = 0; m_wl = 0; m_rt = 0; m_cfg = 1; m_busy = 0; m_idx = 0;
        end else begin
            was_busy = m_busy;
            if (m_busy) begin
                op  = int'(m_cmd[31:27]);
                sid = int'(m_cmd[23:20]);
                lo  = int'(m_cmd[19:4]) % WINB;
                cnt = int'(m_cmd[2:0]);
                isw = (op == 0 || op == 2 || op == 14 || op == 16);
                isr = (op == 1 || op == 13 || op == 15);
                isc = (op >= 3 && op <= 6);
                if (!m_cfg || !(isw || isr || isc)) begin
                    m_sts = m_sts | 4'h5; m_busy = 0;
                end else if (!PRES[sid] || (!isc && !m_awake[sid])) begin
                    m_sts = m_sts | 4'h3; m_busy = 0;
                end else if (isc) begin
                    if (op == 3) begin
                        for (int w = 0; w < WINB; w++) m_mem[sid][w] = 8'h00;
                        m_awake[sid] = 1'b1;
                    end else m_awake[sid] = (op == 6);
                    m_sts = m_sts | 4'h1; m_busy = 0;
                end else begin
                    n = (op >= 14) ? 1 : cnt + 1;
                    k = (op == 16) ? 0 : (lo + m_idx) % WINB;
                    if (isw) m_mem[sid][k] = (op == 16) ? {1'b0, m_wl[6:0]} : m_wl[m_idx*8 +: 8];
                    else     m_rt[m_idx*8 +: 8] = m_mem[sid][k];
                    m_idx++;
                    if (m_idx == n) begin
                        m_sts = m_sts | 4'h1; m_busy = 0;
                        if (isr) begin m_rd0 = m_rt[31:0]; m_rd1 = m_rt[63:32]; end
                    end
                end
            end
            if (bus_we) begin
                case (bus_addr)
                    5'h00: if (was_busy) m_sts = m_sts | 4'h8;
                           else begin
                               m_sts = 0; m_cmd = bus_wdata; m_busy = 1; m_idx = 0;
                               m_rt = 0; m_wl = {m_wd1, m_wd0};
                           end
                    5'h04: m_cfg = bus_wdata[0];
                    5'h10: m_wd0 = bus_wdata;
                    5'h14: m_wd1 = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h04:   return {31'b0, m_cfg};
            5'h08:   return {28'b0, m_sts};
            5'h10:   return m_wd0;
            5'h14:   return m_wd1;
            5'h18:   return m_rd0;
            5'h1C:   return m_rd1;
            default: return 32'h0;
        endcase
    endfunction

    // compare the visible register against the model every cycle (R1, R5, R12)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (bus_rdata !== m_read(bus_addr)) begin
                errors++;
                $display("FAIL R5 cycle model at offset %h: got %h exp %h",
                         bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int sid, input int a, input int cnt);
        return {op[4:0], 3'b000, sid[3:0], a[15:0], 1'b0, cnt[2:0]};
    endfunction

    task automatic bw(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wait_done(output logic [31:0] s, output int lat);
        int k = 0;
        bus_addr = 5'h08;
        do begin
            @(negedge clk);
            k++;
            s = bus_rdata;
        end while (!s[0] && k < 100);
        lat = k - 1;
    endtask

    task automatic issue(input logic [31:0] cmd, input int exp_lat, input logic [3:0] exp_sts,
                         input string tag);
        logic [31:0] s;
        int lat;
        bw(5'h00, cmd);
        bus_addr = 5'h08;
        @(negedge clk);
        chk({tag, " R5 status cleared on accept"}, bus_rdata, 32'h0);
        wait_done(s, lat);
        chk({tag, " latency"}, 32'(lat + 1), 32'(exp_lat));
        chk({tag, " status"}, s, {28'b0, exp_sts});
    endtask

    task automatic rdwords(input string tag, input logic [31:0] e0, input logic [31:0] e1);
        logic [31:0] v;
        rdreg(5'h18, v); chk({tag, " rd word0"}, v, e0);
        rdreg(5'h1C, v); chk({tag, " rd word1"}, v, e1);
    endtask

    initial begin
        #(T_CLK * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, s;
        int lat;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        rdreg(5'h08, v); chk("R1 status reset", v, 32'h0);
        rdreg(5'h04, v); chk("R1 config reset", v, 32'h1);
        rdreg(5'h18, v); chk("R1 rd0 reset", v, 32'h0);
        rdreg(5'h10, v); chk("R1 wd0 reset", v, 32'h0);

        // R2 R3 R4: three byte write then read back
        bw(5'h10, 32'h00CCBBAA);
        issue(mk(0, 0, 16'h0105, 2), 3, 4'h1, "R3 write 3 bytes");
        issue(mk(1, 0, 16'h0105, 2), 3, 4'h1, "R2 read 3 bytes");
        rdwords("R4 three bytes", 32'h00CCBBAA, 32'h0);

        // R3 R4: eight bytes wrapping across the window end
        bw(5'h10, 32'h44332211);
        bw(5'h14, 32'h88776655);
        issue(mk(2, 0, 16'h001E, 7), 8, 4'h1, "R3 write 8 bytes wrap");
        issue(mk(13, 0, 16'h001E, 7), 8, 4'h1, "R3 read 8 bytes wrap");
        rdwords("R4 eight bytes", 32'h44332211, 32'h88776655);
        issue(mk(1, 0, 16'h001E, 4), 5, 4'h1, "R4 read 5 bytes");
        rdwords("R4 five bytes", 32'h44332211, 32'h00000055);

        // R6: single-byte opcodes ignore the length field
        bw(5'h10, 32'h000000EE);
        issue(mk(14, 0, 16'h0003, 7), 1, 4'h1, "R6 short write");
        issue(mk(1, 0, 16'h0003, 1), 2, 4'h1, "R6 neighbour read");
        rdwords("R6 neighbour kept", 32'h000077EE, 32'h0);
        issue(mk(15, 0, 16'h0003, 7), 1, 4'h1, "R6 short read");
        rdwords("R6 short read data", 32'h000000EE, 32'h0);

        // R7: zero-write
        bw(5'h10, 32'h000000FF);
        issue(mk(16, 0, 16'h000A, 5), 1, 4'h1, "R7 zero write");
        issue(mk(1, 0, 16'h0000, 0), 1, 4'h1, "R7 read reg0");
        rdwords("R7 seven bits", 32'h0000007F, 32'h0);

        // R11 R12: absent slave
        issue(mk(1, 9, 16'h0000, 0), 1, 4'h3, "R11 absent read");
        rdwords("R12 hold after failed read", 32'h0000007F, 32'h0);
        issue(mk(0, 9, 16'h0000, 0), 1, 4'h3, "R11 absent write");
        issue(mk(4, 9, 16'h0000, 0), 1, 4'h3, "R11 absent sleep");

        // R9: undefined opcodes
        issue(mk(9, 0, 16'h0000, 0), 1, 4'h5, "R9 opcode 9");
        issue(mk(20, 0, 16'h0000, 3), 1, 4'h5, "R9 opcode 20");
        rdwords("R12 hold after reject", 32'h0000007F, 32'h0);

        // R8: non-data commands
        bw(5'h10, 32'h0000005A);
        issue(mk(0, 1, 16'h0000, 0), 1, 4'h1, "R8 seed slave1");
        issue(mk(4, 0, 16'h0000, 0), 1, 4'h1, "R8 sleep");
        issue(mk(1, 0, 16'h0000, 0), 1, 4'h3, "R8 read while asleep");
        issue(mk(6, 0, 16'h0000, 0), 1, 4'h1, "R8 wakeup");
        issue(mk(1, 0, 16'h0000, 0), 1, 4'h1, "R8 read after wake");
        rdwords("R8 data kept over sleep", 32'h0000007F, 32'h0);
        issue(mk(5, 0, 16'h0000, 0), 1, 4'h1, "R8 shutdown");
        issue(mk(0, 0, 16'h0000, 0), 1, 4'h3, "R8 write while down");
        issue(mk(3, 0, 16'h0000, 0), 1, 4'h1, "R8 reset");
        issue(mk(1, 0, 16'h0000, 1), 2, 4'h1, "R8 read after reset");
        rdwords("R8 cleared", 32'h0, 32'h0);
        issue(mk(1, 1, 16'h0000, 0), 1, 4'h1, "R8 other slave");
        rdwords("R8 other slave kept", 32'h0000005A, 32'h0);

        // R10: command while busy
        bw(5'h10, 32'h11111111);
        bw(5'h14, 32'h22222222);
        bw(5'h00, mk(0, 0, 16'h0000, 7));
        bw(5'h00, mk(0, 2, 16'h0000, 0));
        rdreg(5'h08, v); chk("R10 dropped while busy", v, 32'h8);
        wait_done(s, lat);
        chk("R10 final status", s, 32'h9);
        issue(mk(1, 2, 16'h0000, 0), 1, 4'h1, "R10 discarded target");
        rdwords("R10 no write", 32'h0, 32'h0);
        issue(mk(13, 0, 16'h0000, 7), 8, 4'h1, "R10 first completed");
        rdwords("R10 first data", 32'h11111111, 32'h22222222);

        // R13: engine disabled
        bw(5'h04, 32'h0);
        rdreg(5'h04, v); chk("R13 config cleared", v, 32'h0);
        bw(5'h10, 32'h000000AB);
        issue(mk(0, 0, 16'h0000, 0), 1, 4'h5, "R13 disabled write");
        bw(5'h04, 32'h1);
        issue(mk(1, 0, 16'h0000, 0), 1, 4'h1, "R13 read after enable");
        rdwords("R13 no change", 32'h00000011, 32'h0);

        // R1: read-only words ignore writes, data words read back
        bw(5'h18, 32'hDEADBEEF);
        bw(5'h08, 32'hFFFFFFFF);
        rdreg(5'h18, v); chk("R1 rd0 ignores write", v, 32'h00000011);
        rdreg(5'h08, v); chk("R1 status ignores write", v, 32'h1);
        rdreg(5'h14, v); chk("R1 wd1 readback", v, 32'h22222222);
        rdreg(5'h00, v); chk("R1 command reads zero", v, 32'h0);

        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule